// File: doc/BRIEF.md
# Byte-Wide Non-Volatile Memory Page Write Engine

This block is a synchronous, cycle-level model of how a byte-wide non-volatile memory commits writes. It watches a bus of active-low chip select, output enable and write strobe, together with an address and a data byte. Each qualified write strobe puts one byte into a page buffer and restarts a byte-load window. Once that window runs out with no new byte, a self-timed commit copies every buffered byte into the storage array in a single operation. While the commit runs, reads return a progress word instead of array contents.

A host streams up to one page of bytes with short gaps between them, then polls. It can compare bit 7 of a read with the last byte it wrote, or watch bit 6 change from one read to the next. When the read returns the true byte, the commit is done. After reset, writes are blocked for a settling period. Every duration (minimum strobe width, load window, commit length, power-up inhibit) is a count of clock cycles set by a parameter. The default geometry is 2^ADDR_W = 2048 bytes in 32-byte pages. Setting ADDR_W to 13 gives an 8192-byte array.

Top module: `nvm_page_engine`

## Requirements
- R1: The low PAGE_BITS (5) address bits select a byte inside a page. The remaining upper bits select the page row. A commit writes only into the row held by the buffer.
- R2: `dout_en` is 1 only while `ce_n`=0, `oe_n`=0 and `we_n`=1. In every other combination it is 0, which means the data bus is released. This includes `ce_n`=1, and `oe_n`=1 with `we_n`=1.
- R3: A byte is taken only from a strobe during which `ce_n`=0, `we_n`=0 and `oe_n`=1 hold together for at least MIN_PULSE (4) consecutive clock edges. A shorter strobe, or one with `oe_n`=0 or `ce_n`=1, changes nothing.
- R4: Every accepted byte restarts the load window. The window does not advance while a write strobe is active. The commit begins only after LOAD_WIN (24) consecutive cycles with no strobe, so bytes that arrive closer together than that join one commit.
- R5: Any number of bytes from 1 to 32 are stored by one commit, which lasts COMMIT_CYC (200) cycles. After it ends, every loaded byte reads back as written.
- R6: The page row is fixed by the first byte loaded in a cycle. A later byte whose row bits differ is discarded.
- R7: Bytes of the page that were not loaded keep their earlier array contents.
- R8: While the commit runs, a read returns the inverse of bit 7 of the last loaded byte in bit 7. Bit 6 changes value after each completed read.
- R9: Write strobes that arrive while a commit runs are discarded.
- R10: For INIT_CYC (40) cycles after reset, write strobes are discarded. Array contents survive a reset.
- R11: Outside a commit, a read returns the array byte at the addressed location.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write strobe, active low |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Write data |
| dout | output | 8 | Read data or progress word, zero when not driven |
| dout_en | output | 1 | Bus drive enable (0 means high impedance) |

## Verification
The bound checker watches, on every cycle, the internal invariants of the engine:
- the page buffer stays empty through the inhibit period and is never empty during a commit;
- the buffer is frozen while a commit runs;
- the page row does not move once the first byte is loaded;
- a commit starts only from the load state with no strobe active, and lasts exactly COMMIT_CYC cycles;
- no byte is accepted from a strobe shorter than the minimum.

Only the bench scenarios can show the visible behaviour. These are:
- the progress word during a commit, with its bit-7 inversion and bit-6 alternation;
- that unloaded and rejected bytes still hold their old values;
- that restarting the window delays the commit;
- that array contents survive a second reset.

// File: rtl/npe_pkg.sv
`timescale 1ns/1ps
package npe_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        ENG_INHIBIT,
        ENG_IDLE,
        ENG_LOAD,
        ENG_COMMIT
    } eng_state_e;

    typedef enum logic [1:0] {
        BUS_STANDBY,
        BUS_READ,
        BUS_WRITE,
        BUS_QUIET
    } bus_mode_e;

    function automatic bus_mode_e decode_bus(input logic cs_n, input logic oen_n,
                                             input logic wen_n);
        if (cs_n)
            return BUS_STANDBY;
        if (!wen_n && oen_n)
            return BUS_WRITE;
        if (wen_n && !oen_n)
            return BUS_READ;
        return BUS_QUIET;
    endfunction

    function automatic logic [BYTE_W-1:0] progress_word(input logic [BYTE_W-1:0] last_b,
                                                        input logic flip);
        return {~last_b[7], flip, last_b[5:0]};
    endfunction

endpackage

// File: rtl/npe_strobe_qual.sv
`timescale 1ns/1ps
module npe_strobe_qual #(
    parameter int ADDR_W    = 11,
    parameter int MIN_PULSE = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_cond,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [npe_pkg::BYTE_W-1:0] din,
    output logic                      acc_vld,
    output logic [ADDR_W-1:0]         acc_addr,
    output logic [npe_pkg::BYTE_W-1:0] acc_data,
    output logic [$clog2(MIN_PULSE+1)-1:0] low_cnt
);
    localparam int CW = $clog2(MIN_PULSE + 1);
    localparam logic [CW-1:0] SAT = CW'(MIN_PULSE);

    always_ff @(posedge clk) begin
        if (rst) begin
            low_cnt <= '0;
            acc_vld <= 1'b0;
        end else begin
            acc_vld <= 1'b0;
            if (wr_cond) begin
                if (low_cnt != SAT)
                    low_cnt <= low_cnt + 1'b1;
            end else begin
                if (low_cnt == SAT)
                    acc_vld <= 1'b1;
                low_cnt <= '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (wr_cond) begin
            acc_addr <= addr;
            acc_data <= din;
        end
    end

endmodule

// File: rtl/npe_page_buf.sv
`timescale 1ns/1ps
module npe_page_buf #(
    parameter int ADDR_W    = 11,
    parameter int PAGE_BITS = 5,
    localparam int PAGE     = 1 << PAGE_BITS,
    localparam int ROW_W    = ADDR_W - PAGE_BITS
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          ld_en,
    input  logic [ADDR_W-1:0]             ld_addr,
    input  logic [npe_pkg::BYTE_W-1:0]    ld_data,
    input  logic                          clr,
    output logic [PAGE-1:0]               pg_mask,
    output logic [PAGE*npe_pkg::BYTE_W-1:0] pg_data,
    output logic [ROW_W-1:0]              pg_row,
    output logic [npe_pkg::BYTE_W-1:0]    last_byte
);
    logic                 any_loaded;
    logic                 row_ok;
    logic [PAGE_BITS-1:0] off;
    logic [ROW_W-1:0]     in_row;

    assign off        = ld_addr[PAGE_BITS-1:0];
    assign in_row     = ld_addr[ADDR_W-1:PAGE_BITS];
    assign any_loaded = |pg_mask;
    assign row_ok     = !any_loaded || (in_row == pg_row);

    always_ff @(posedge clk) begin
        if (rst) begin
            pg_mask   <= '0;
            pg_row    <= '0;
            last_byte <= '0;
        end else if (clr) begin
            pg_mask <= '0;
        end else if (ld_en && row_ok) begin
            pg_mask[off] <= 1'b1;
            last_byte    <= ld_data;
            if (!any_loaded)
                pg_row <= in_row;
        end
    end

    always_ff @(posedge clk) begin
        if (!clr && ld_en && row_ok)
            pg_data[off*npe_pkg::BYTE_W +: npe_pkg::BYTE_W] <= ld_data;
    end

endmodule

// File: rtl/npe_store.sv
`timescale 1ns/1ps
module npe_store #(
    parameter int ADDR_W    = 11,
    parameter int PAGE_BITS = 5,
    localparam int PAGE     = 1 << PAGE_BITS,
    localparam int DEPTH    = 1 << ADDR_W,
    localparam int ROW_W    = ADDR_W - PAGE_BITS
) (
    input  logic                            clk,
    input  logic                            wr_en,
    input  logic [ROW_W-1:0]                wr_row,
    input  logic [PAGE-1:0]                 wr_mask,
    input  logic [PAGE*npe_pkg::BYTE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0]               rd_addr,
    output logic [npe_pkg::BYTE_W-1:0]      rd_data
);
    logic [npe_pkg::BYTE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        for (int i = 0; i < PAGE; i++) begin
            if (wr_en && wr_mask[i])
                mem[{wr_row, PAGE_BITS'(i)}] <= wr_data[i*npe_pkg::BYTE_W +: npe_pkg::BYTE_W];
        end
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/nvm_page_engine.sv
`timescale 1ns/1ps
module nvm_page_engine #(
    parameter int ADDR_W     = 11,
    parameter int PAGE_BITS  = 5,
    parameter int MIN_PULSE  = 4,
    parameter int LOAD_WIN   = 24,
    parameter int COMMIT_CYC = 200,
    parameter int INIT_CYC   = 40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    output logic [7:0]        dout,
    output logic              dout_en
);
    import npe_pkg::*;

    localparam int PAGE    = 1 << PAGE_BITS;
    localparam int ROW_W   = ADDR_W - PAGE_BITS;
    localparam int CNT_MAX = (LOAD_WIN > COMMIT_CYC) ?
                             ((LOAD_WIN > INIT_CYC) ? LOAD_WIN : INIT_CYC) :
                             ((COMMIT_CYC > INIT_CYC) ? COMMIT_CYC : INIT_CYC);
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam int QW      = $clog2(MIN_PULSE + 1);

    eng_state_e             state;
    logic [CNT_W-1:0]       cnt;
    logic                   flip;
    logic                   rd_q;
    bus_mode_e              mode;
    logic                   wr_cond;
    logic                   rd_act;
    logic                   acc_vld;
    logic [ADDR_W-1:0]      acc_addr;
    logic [BYTE_W-1:0]      acc_data;
    logic [QW-1:0]          low_cnt;
    logic                   ld_en;
    logic                   commit_fire;
    logic [PAGE-1:0]        pg_mask;
    logic [PAGE*BYTE_W-1:0] pg_data;
    logic [ROW_W-1:0]       pg_row;
    logic [BYTE_W-1:0]      last_byte;
    logic [BYTE_W-1:0]      rd_data;

    assign mode        = decode_bus(ce_n, oe_n, we_n);
    assign wr_cond     = (mode == BUS_WRITE);
    assign rd_act      = (mode == BUS_READ);
    assign commit_fire = (state == ENG_COMMIT) && (cnt == CNT_W'(COMMIT_CYC - 1));
    assign ld_en       = acc_vld && ((state == ENG_IDLE) || (state == ENG_LOAD));

    npe_strobe_qual #(.ADDR_W(ADDR_W), .MIN_PULSE(MIN_PULSE)) u_qual (
        .clk      (clk),
        .rst      (rst),
        .wr_cond  (wr_cond),
        .addr     (addr),
        .din      (din),
        .acc_vld  (acc_vld),
        .acc_addr (acc_addr),
        .acc_data (acc_data),
        .low_cnt  (low_cnt)
    );

    npe_page_buf #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_buf (
        .clk       (clk),
        .rst       (rst),
        .ld_en     (ld_en),
        .ld_addr   (acc_addr),
        .ld_data   (acc_data),
        .clr       (commit_fire),
        .pg_mask   (pg_mask),
        .pg_data   (pg_data),
        .pg_row    (pg_row),
        .last_byte (last_byte)
    );

    npe_store #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_store (
        .clk     (clk),
        .wr_en   (commit_fire),
        .wr_row  (pg_row),
        .wr_mask (pg_mask),
        .wr_data (pg_data),
        .rd_addr (addr),
        .rd_data (rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ENG_INHIBIT;
            cnt   <= '0;
        end else begin
            unique case (state)
                ENG_INHIBIT: begin
                    if (cnt == CNT_W'(INIT_CYC - 1)) begin
                        state <= ENG_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ENG_IDLE: begin
                    if (acc_vld) begin
                        state <= ENG_LOAD;
                        cnt   <= '0;
                    end
                end
                ENG_LOAD: begin
                    if (acc_vld) begin
                        cnt <= '0;
                    end else if (!wr_cond) begin
                        if (cnt == CNT_W'(LOAD_WIN - 1)) begin
                            state <= ENG_COMMIT;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                ENG_COMMIT: begin
                    if (commit_fire) begin
                        state <= ENG_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= ENG_INHIBIT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flip <= 1'b0;
            rd_q <= 1'b0;
        end else begin
            rd_q <= rd_act;
            if (rd_q && !rd_act && (state == ENG_COMMIT))
                flip <= ~flip;
        end
    end

    always_comb begin
        dout_en = rd_act;
        if (!rd_act)
            dout = '0;
        else if (state == ENG_COMMIT)
            dout = progress_word(last_byte, flip);
        else
            dout = rd_data;
    end

endmodule

// File: rtl/npe_checker.sv
`timescale 1ns/1ps
module npe_checker #(
    parameter int ADDR_W     = 11,
    parameter int PAGE_BITS  = 5,
    parameter int MIN_PULSE  = 4,
    parameter int COMMIT_CYC = 200
) (
    input logic                             clk,
    input logic                             rst,
    input npe_pkg::eng_state_e              state,
    input logic                             wr_cond,
    input logic                             acc_vld,
    input logic                             commit_fire,
    input logic [$clog2(MIN_PULSE+1)-1:0]   low_cnt,
    input logic [(1<<PAGE_BITS)-1:0]        pg_mask,
    input logic [ADDR_W-PAGE_BITS-1:0]      pg_row
);
    import npe_pkg::*;

    localparam int QW = $clog2(MIN_PULSE + 1);
    localparam int LW = $clog2(COMMIT_CYC + 2);

    logic [LW-1:0] busy_len;
    logic          in_commit;

    assign in_commit = (state == ENG_COMMIT);

    always_ff @(posedge clk) begin
        if (rst)
            busy_len <= '0;
        else if (in_commit)
            busy_len <= busy_len + 1'b1;
        else
            busy_len <= '0;
    end

    // R10: nothing is buffered during the power-up inhibit
    p_inhibit_empty_r10: assert property (@(posedge clk) disable iff (rst)
        (state == ENG_INHIBIT) |-> (pg_mask == '0));

    // R9: buffer frozen while the commit runs
    p_commit_frozen_r9: assert property (@(posedge clk) disable iff (rst)
        (in_commit && !commit_fire) |=> $stable(pg_mask));

    // R6: row does not move once the first byte is held
    p_row_locked_r6: assert property (@(posedge clk) disable iff (rst)
        ((|pg_mask) && (state == ENG_LOAD)) |=> $stable(pg_row));

    // R4: commit begins only from the load state with no strobe active
    p_commit_after_window_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(in_commit) |-> ($past(state) == ENG_LOAD && !$past(wr_cond)));

    // R5: a commit always has at least one byte to store
    p_commit_nonempty_r5: assert property (@(posedge clk) disable iff (rst)
        in_commit |-> (pg_mask != '0));

    // R5: commit length is exactly COMMIT_CYC cycles
    p_commit_len_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(in_commit) |-> (busy_len == LW'(COMMIT_CYC)));

    // R3: an accepted byte came from a strobe of at least the minimum width
    p_min_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        acc_vld |-> ($past(low_cnt) == QW'(MIN_PULSE)));

endmodule

bind nvm_page_engine npe_checker #(
    .ADDR_W     (ADDR_W),
    .PAGE_BITS  (PAGE_BITS),
    .MIN_PULSE  (MIN_PULSE),
    .COMMIT_CYC (COMMIT_CYC)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .state       (state),
    .wr_cond     (wr_cond),
    .acc_vld     (acc_vld),
    .commit_fire (commit_fire),
    .low_cnt     (low_cnt),
    .pg_mask     (pg_mask),
    .pg_row      (pg_row)
);

// File: tb/nvm_page_engine_tb.sv
`timescale 1ns/1ps
module nvm_page_engine_tb;

    localparam int AW   = 11;
    localparam int PB   = 5;
    localparam int MINP = 4;
    localparam int LW   = 24;
    localparam int CC   = 200;
    localparam int IC   = 40;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ce_n = 1'b1;
    logic          oe_n = 1'b1;
    logic          we_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [7:0]    din = '0;
    logic [7:0]    dout;
    logic          dout_en;

    int n_chk  = 0;
    int n_fail = 0;
    logic [7:0] model [1<<AW];

    always #2.5 clk = ~clk;

    nvm_page_engine #(
        .ADDR_W(AW), .PAGE_BITS(PB), .MIN_PULSE(MINP),
        .LOAD_WIN(LW), .COMMIT_CYC(CC), .INIT_CYC(IC)
    ) u_dut (
        .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .din(din), .dout(dout), .dout_en(dout_en)
    );

    function automatic logic [7:0] pat(input int row, input int idx);
        return 8'((row * 37 + idx * 11) ^ 8'h5C);
    endfunction

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d, input int width);
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b0; addr = a; din = d;
        repeat (width) @(negedge clk);
        we_n = 1'b1; ce_n = 1'b1;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [7:0] d, output logic en);
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = a;
        #1;
        d  = dout;
        en = dout_en;
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic poll(input logic [AW-1:0] a, input logic [7:0] exp,
                        output bit found, output int cyc);
        logic [7:0] d;
        logic en;
        found = 1'b0;
        cyc = 0;
        for (int k = 0; k < (CC + LW + 40) / 2; k++) begin
            rd(a, d, en);
            cyc += 2;
            if (d == exp) begin
                found = 1'b1;
                break;
            end
        end
    endtask

    task automatic check_row(input string req, input int row);
        logic [7:0] d;
        logic en;
        for (int i = 0; i < 32; i++) begin
            rd(AW'(row * 32 + i), d, en);
            chk(req, d, model[row * 32 + i]);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        report();
        $finish;
    end

    initial begin
        logic [7:0] d, d2;
        logic en;
        bit found;
        int cyc;

        waitc(3);
        chk("R2 reset idle bus released", {7'd0, dout_en}, 8'd0);
        rst = 1'b0;
        waitc(IC + 2);

        // R2 bus drive decode
        ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b1; #1;
        chk("R2 oe high we high no drive", {7'd0, dout_en}, 8'd0);
        ce_n = 1'b1; oe_n = 1'b0; #1;
        chk("R2 standby no drive", {7'd0, dout_en}, 8'd0);
        oe_n = 1'b1;
        rd(AW'(0), d, en);
        chk("R2 read drives bus", {7'd0, en}, 8'd1);

        // R5 R1 full page writes on rows 1 and 2
        for (int r = 1; r <= 2; r++) begin
            for (int i = 0; i < 32; i++) begin
                wr(AW'(r * 32 + i), pat(r, i), MINP + 1);
                model[r * 32 + i] = pat(r, i);
            end
            waitc(LW + 4);
            rd(AW'(r * 32 + 31), d, en);
            rd(AW'(r * 32 + 31), d2, en);
            chk("R8 status bit7 inverted", {7'd0, d[7]}, {7'd0, ~pat(r, 31)[7]});
            chk("R8 status bit6 alternates", {7'd0, d[6] ^ d2[6]}, 8'd1);
            poll(AW'(r * 32 + 31), pat(r, 31), found, cyc);
            chk("R11 commit completes", {7'd0, found}, 8'd1);
            chk("R5 commit within budget", {7'd0, cyc <= CC}, 8'd1);
            check_row("R5 R1 page contents", r);
        end

        // R7 single byte, R9 write during commit ignored
        wr(AW'('h25), 8'h11, MINP);
        model['h25] = 8'h11;
        waitc(LW + 4);
        wr(AW'('h26), 8'hEE, MINP + 2);
        poll(AW'('h25), 8'h11, found, cyc);
        chk("R5 single byte committed", {7'd0, found}, 8'd1);
        waitc(LW + CC + 10);
        check_row("R7 R9 neighbours kept", 1);

        // R6 row lock
        wr(AW'('h30), 8'h77, MINP);
        wr(AW'('h45), 8'h99, MINP);
        model['h30] = 8'h77;
        waitc(LW + 4);
        poll(AW'('h30), 8'h77, found, cyc);
        chk("R6 first row byte stored", {7'd0, found}, 8'd1);
        rd(AW'('h45), d, en);
        chk("R6 other row discarded", d, model['h45]);

        // R4 window restart
        wr(AW'('h22), 8'h3C, MINP);
        waitc(LW - 6);
        wr(AW'('h23), 8'hC3, MINP);
        waitc(LW - 6);
        rd(AW'('h22), d, en);
        chk("R4 window restarted no commit yet", d, model['h22]);
        model['h22] = 8'h3C;
        model['h23] = 8'hC3;
        poll(AW'('h23), 8'hC3, found, cyc);
        chk("R4 late byte stored", {7'd0, found}, 8'd1);
        rd(AW'('h22), d, en);
        chk("R4 early byte in same commit", d, 8'h3C);

        // R3 rejected strobes
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b0; addr = AW'('h24); din = 8'h00;
        waitc(MINP + 2);
        ce_n = 1'b1;
        waitc(MINP + 2);
        we_n = 1'b1; oe_n = 1'b1;
        wr(AW'('h21), 8'h00, MINP - 1);
        waitc(LW + CC + 10);
        rd(AW'('h24), d, en);
        chk("R3 strobe with oe low ignored", d, model['h24]);
        rd(AW'('h21), d, en);
        rd(AW'('h21), d2, en);
        chk("R3 glitch strobe ignored", d, model['h21]);
        chk("R3 no busy after glitch", d2, d);

        // R10 inhibit after a second reset
        @(negedge clk);
        rst = 1'b1;
        waitc(2);
        rst = 1'b0;
        wr(AW'('h2A), ~model['h2A], MINP + 2);
        waitc(IC + LW + CC + 10);
        rd(AW'('h2A), d, en);
        chk("R10 write during inhibit discarded", d, model['h2A]);
        wr(AW'('h2A), 8'h42, MINP);
        model['h2A] = 8'h42;
        waitc(LW + 4);
        poll(AW'('h2A), 8'h42, found, cyc);
        chk("R10 write after inhibit stored", {7'd0, found}, 8'd1);
        check_row("R10 R11 array survives reset", 1);

        report();
        $finish;
    end

endmodule